// File: doc/BRIEF.md
# Reset, Sleep and Strap Controller

This block brings a bridge device out of power-on reset or external reset, runs its deep power-saving entry and wake-up, and captures the board configuration straps at three defined moments. The straps are captured at power-on, when the external reset is released, and when the device wakes from deep sleep. At all other times the captured values stay frozen. One strap is a three-level bus-mode pin, already digitized to a 2-bit code. The block decodes it into a serial-bus role (slave or master) and a slave address.

The sequencer moves through RESET, INIT (a fixed strap capture window), ACTIVE, a programmable power-down countdown, and SLEEP. Waking goes SLEEP, then INIT, then ACTIVE. The hot-plug-detect output is high only while ACTIVE. A power-down request that arrives while video is streaming still leads to sleep, and a warning flag records that event. A power-down input marked as floating never causes sleep. Release of either reset and the power-down inputs pass through two-flop synchronizers. The reset is applied asynchronously.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After `por_n` and `ext_rst_n` are both high, `hpd_o` rises exactly 7 clock edges after the release is presented. This is 2 synchronizer stages, 1 RESET cycle and an INIT window of 4 cycles.
- R2: Either `por_n` or `ext_rst_n` low forces `hpd_o`, `sleep_o`, `pd_warn` and `core_rst_n` low at once, with no clock needed. The decoded role returns to slave at address 0x40 and `cfg_q` returns to 0.
- R3: Strap code decode: 2'b00 gives slave at 8'h40, 2'b01 gives slave at 8'hC0, and 2'b10 gives master (`bus_master`=1, `slave_addr`=8'h00). The illegal code 2'b11 gives slave at 8'h40.
- R4: `strap_mode` and `strap_cfg` are captured only on the last INIT cycle. Changes while ACTIVE, counting down or asleep do not alter `bus_master`, `slave_addr` or `cfg_q`.
- R5: `pd_req_n` driven low while ACTIVE drops `hpd_o` after 3 edges and raises `sleep_o` after 19 edges (PD_CYC=16 by default).
- R6: While `pd_float` is high, `pd_req_n` low never leads to sleep, and `hpd_o` stays high.
- R7: `hpd_o` is high only in ACTIVE and is low whenever `sleep_o` is high.
- R8: `pd_req_n` returning high in SLEEP re-runs INIT. Straps are recaptured, and `hpd_o` rises 7 edges after the release is presented.
- R9: `pd_warn` is set when a power-down is accepted while `video_on` is high. It holds through sleep, is cleared when wake-up starts, and is never set when `video_on` is low.
- R10: A power-down request that is active at the end of INIT goes straight to the countdown after the straps are captured. `hpd_o` never rises, and `sleep_o` rises 23 edges after reset release.
- R11: `core_rst_n` is high exactly in ACTIVE and during the countdown. It is low in RESET, INIT and SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low |
| ext_rst_n | input | 1 | External reset, active low |
| pd_req_n | input | 1 | Power-down request, active low |
| pd_float | input | 1 | High when the power-down pin is sensed floating |
| strap_mode | input | 2 | Digitized three-level bus-mode strap |
| strap_cfg | input | CFG_W | Other configuration straps |
| video_on | input | 1 | Video streaming status |
| core_rst_n | output | 1 | Synchronous reset for the rest of the device, active low |
| cfg_q | output | CFG_W | Captured configuration straps |
| bus_master | output | 1 | 1 = serial bus master role |
| slave_addr | output | 8 | 8-bit slave address (0 in master role) |
| sleep_o | output | 1 | Deep sleep indication |
| hpd_o | output | 1 | Hot-plug-detect |
| pd_warn | output | 1 | Power-down accepted while streaming |

## Verification
Two things can happen in the same cycle: the strap capture at the end of INIT and the acceptance of a power-down request. The bench provokes this by holding `pd_req_n` low with `video_on` high across an external reset pulse, so the request is already synchronized when INIT finishes. It then checks three things. `hpd_o` never rises. Sleep arrives at the predicted 23rd edge. The new strap address and the warning flag are both present, which shows that neither event suppressed the other.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_INIT   = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_PD_SEQ = 3'd3,
    ST_SLEEP  = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic       master;
    logic [7:0] addr;
  } bus_role_t;

  // 00 low -> slave low addr, 01 open -> slave high addr,
  // 10 high -> master, 11 illegal -> slave low addr
  function automatic bus_role_t decode_strap(input logic [1:0] code,
                                             input logic [7:0] lo_addr,
                                             input logic [7:0] hi_addr);
    bus_role_t r;
    case (code)
      2'b01:   begin r.master = 1'b0; r.addr = hi_addr; end
      2'b10:   begin r.master = 1'b1; r.addr = 8'h00;   end
      default: begin r.master = 1'b0; r.addr = lo_addr; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/pwr_sync_bits.sv
module pwr_sync_bits #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= RST_VAL;
        else        st_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= RST_VAL;
        else        st_q[g] <= st_q[g-1];
      end
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/pwr_strap_latch.sv
module pwr_strap_latch
  import pwr_seq_pkg::*;
#(
  parameter int         CFG_W   = 4,
  parameter logic [7:0] ADDR_LO = 8'h40,
  parameter logic [7:0] ADDR_HI = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [1:0]       strap_mode,
  input  logic [CFG_W-1:0] strap_cfg,
  output logic [CFG_W-1:0] cfg_q,
  output logic             bus_master,
  output logic [7:0]       slave_addr
);
  localparam bus_role_t ROLE_RST = '{master: 1'b0, addr: ADDR_LO};

  bus_role_t role_q, role_d;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    role_d = role_q;
    cfg_d  = cfg_q;
    if (cap_en) begin
      role_d = decode_strap(strap_mode, ADDR_LO, ADDR_HI);
      cfg_d  = strap_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_q <= ROLE_RST;
      cfg_q  <= '0;
    end else begin
      role_q <= role_d;
      cfg_q  <= cfg_d;
    end
  end

  assign bus_master = role_q.master;
  assign slave_addr = role_q.addr;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int INIT_CYC = 4,
  parameter int PD_CYC   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_act,
  input  logic       video_on,
  output seq_state_t state_o,
  output logic       cap_en,
  output logic       pd_done,
  output logic       pd_warn
);
  localparam int MAXC  = (INIT_CYC > PD_CYC) ? INIT_CYC : PD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] PD_LOAD   = CNT_W'(PD_CYC - 1);

  seq_state_t st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic warn_q, warn_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    warn_d = warn_q;
    cap_en = 1'b0;
    case (st_q)
      ST_RESET: begin
        st_d  = ST_INIT;
        cnt_d = '0;
      end
      ST_INIT: begin
        if (cnt_q == INIT_LAST) begin
          cap_en = 1'b1;
          if (pd_act) begin
            st_d  = ST_PD_SEQ;
            cnt_d = PD_LOAD;
            if (video_on) warn_d = 1'b1;
          end else begin
            st_d = ST_ACTIVE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (pd_act) begin
          st_d  = ST_PD_SEQ;
          cnt_d = PD_LOAD;
          if (video_on) warn_d = 1'b1;
        end
      end
      ST_PD_SEQ: begin
        if (cnt_q == '0) st_d = ST_SLEEP;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_SLEEP: begin
        if (!pd_act) begin
          st_d   = ST_INIT;
          cnt_d  = '0;
          warn_d = 1'b0;
        end
      end
      default: st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RESET;
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      warn_q <= warn_d;
    end
  end

  assign state_o = st_q;
  assign pd_done = (st_q == ST_PD_SEQ) && (cnt_q == '0);
  assign pd_warn = warn_q;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int         CFG_W     = 4,
  parameter int         SYNC_STG  = 2,
  parameter int         INIT_CYC  = 4,
  parameter int         PD_CYC    = 16,
  parameter logic [7:0] ADDR_LO   = 8'h40,
  parameter logic [7:0] ADDR_HI   = 8'hC0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             pd_req_n,
  input  logic             pd_float,
  input  logic [1:0]       strap_mode,
  input  logic [CFG_W-1:0] strap_cfg,
  input  logic             video_on,
  output logic             core_rst_n,
  output logic [CFG_W-1:0] cfg_q,
  output logic             bus_master,
  output logic [7:0]       slave_addr,
  output logic             sleep_o,
  output logic             hpd_o,
  output logic             pd_warn
);
  logic       arst_n;
  logic       rst_n_sync;
  logic [1:0] pd_s;
  logic       pd_n_s, float_s, pd_act;
  logic       cap_en, pd_done;
  seq_state_t state_q;

  assign arst_n = por_n & ext_rst_n;

  pwr_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n_o(rst_n_sync)
  );

  pwr_sync_bits #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b10)) u_pd_sync (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .d    ({pd_req_n, pd_float}),
    .q    (pd_s)
  );

  assign pd_n_s  = pd_s[1];
  assign float_s = pd_s[0];
  assign pd_act  = !pd_n_s && !float_s;

  pwr_seq_fsm #(.INIT_CYC(INIT_CYC), .PD_CYC(PD_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .pd_act  (pd_act),
    .video_on(video_on),
    .state_o (state_q),
    .cap_en  (cap_en),
    .pd_done (pd_done),
    .pd_warn (pd_warn)
  );

  pwr_strap_latch #(.CFG_W(CFG_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_strap (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cap_en    (cap_en),
    .strap_mode(strap_mode),
    .strap_cfg (strap_cfg),
    .cfg_q     (cfg_q),
    .bus_master(bus_master),
    .slave_addr(slave_addr)
  );

  assign hpd_o      = (state_q == ST_ACTIVE);
  assign sleep_o    = (state_q == ST_SLEEP);
  assign core_rst_n = (state_q == ST_ACTIVE) || (state_q == ST_PD_SEQ);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input seq_state_t state,
  input logic       pd_done,
  input logic       float_s,
  input logic       video_on,
  input logic       hpd_o,
  input logic       sleep_o,
  input logic       core_rst_n,
  input logic       pd_warn,
  input logic       bus_master,
  input logic [7:0] slave_addr
);
  // R1: reset state always hands over to the INIT window
  assert_reset_to_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |=> (state == ST_INIT));

  // R4: captured role only moves after an INIT cycle
  assert_strap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != ST_INIT) |-> ($stable(slave_addr) && $stable(bus_master)));

  // R5: countdown end lands in sleep
  assert_pd_to_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_done |=> sleep_o);

  // R6: floating power-down never starts the countdown
  assert_float_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && float_s) |=> (state != ST_PD_SEQ));

  // R7: hot-plug-detect and sleep are exclusive
  assert_hpd_off_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !hpd_o);

  // R9: warning only rises after streaming was seen
  assert_warn_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_warn) |-> $past(video_on));

  // R11: core out of reset whenever hot-plug-detect is up
  assert_core_rst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_o |-> core_rst_n);
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .state     (state_q),
  .pd_done   (pd_done),
  .float_s   (float_s),
  .video_on  (video_on),
  .hpd_o     (hpd_o),
  .sleep_o   (sleep_o),
  .core_rst_n(core_rst_n),
  .pd_warn   (pd_warn),
  .bus_master(bus_master),
  .slave_addr(slave_addr)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;
  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, pd_req_n, pd_float, video_on;
  logic [1:0] strap_mode;
  logic [3:0] strap_cfg;
  logic       core_rst_n, bus_master, sleep_o, hpd_o, pd_warn;
  logic [3:0] cfg_q;
  logic [7:0] slave_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pd_req_n(pd_req_n),
    .pd_float(pd_float), .strap_mode(strap_mode), .strap_cfg(strap_cfg),
    .video_on(video_on), .core_rst_n(core_rst_n), .cfg_q(cfg_q),
    .bus_master(bus_master), .slave_addr(slave_addr), .sleep_o(sleep_o),
    .hpd_o(hpd_o), .pd_warn(pd_warn)
  );

  // {strap code, expected master, expected address}
  localparam logic [10:0] VEC [4] = '{
    {2'b00, 1'b0, 8'h40},
    {2'b01, 1'b0, 8'hC0},
    {2'b10, 1'b1, 8'h00},
    {2'b11, 1'b0, 8'h40}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges_to_hpd(input logic lvl, output int n);
    n = 0;
    do begin @(posedge clk); n++; #2; end while (hpd_o != lvl && n < 100);
  endtask

  task automatic edges_to_sleep(inout int n);
    do begin @(posedge clk); n++; #2; end while (!sleep_o && n < 100);
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  initial begin
    int n;
    bit seen;
    por_n = 0; ext_rst_n = 1; pd_req_n = 1; pd_float = 0;
    video_on = 0; strap_mode = 2'b00; strap_cfg = 4'h0;
    repeat (3) @(negedge clk);
    chk("R2 reset hpd", hpd_o, 0);
    chk("R2 reset core_rst_n", core_rst_n, 0);
    chk("R2 reset sleep", sleep_o, 0);
    chk("R2 reset warn", pd_warn, 0);
    chk("R2 reset addr", slave_addr, 8'h40);
    chk("R2 reset cfg", cfg_q, 0);
    por_n = 1;
    edges_to_hpd(1'b1, n);
    chk("R1 power-on release to hpd", n, 7);
    chk("R11 core_rst_n active", core_rst_n, 1);

    // R3 decode table, one external reset per vector
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      strap_mode = VEC[i][10:9];
      strap_cfg  = 4'(i * 3 + 1);
      ext_rst_n  = 0;
      #1;
      chk("R2 async hpd drop", hpd_o, 0);
      chk("R2 async core_rst_n", core_rst_n, 0);
      repeat (2) @(negedge clk);
      ext_rst_n = 1;
      edges_to_hpd(1'b1, n);
      chk("R1 ext release to hpd", n, 7);
      chk("R3 master", bus_master, VEC[i][8]);
      chk("R3 address", slave_addr, VEC[i][7:0]);
      chk("R4 cfg captured", cfg_q, i * 3 + 1);
    end

    // R4 straps ignored while active
    @(negedge clk);
    strap_mode = 2'b01; strap_cfg = 4'hE;
    wait_cyc(5);
    chk("R4 addr held active", slave_addr, 8'h40);
    chk("R4 cfg held active", cfg_q, 10);

    // R5 / R7 / R11 power-down without video
    @(negedge clk);
    pd_req_n = 0;
    edges_to_hpd(1'b0, n);
    chk("R5 hpd drop edges", n, 3);
    chk("R11 core_rst_n in countdown", core_rst_n, 1);
    edges_to_sleep(n);
    chk("R5 sleep edges", n, 19);
    chk("R7 hpd low asleep", hpd_o, 0);
    chk("R11 core_rst_n asleep", core_rst_n, 0);
    chk("R9 no warn without video", pd_warn, 0);
    strap_mode = 2'b10; strap_cfg = 4'h5;
    wait_cyc(3);
    chk("R4 addr held asleep", slave_addr, 8'h40);
    // R8 wake and recapture
    @(negedge clk);
    pd_req_n = 1;
    edges_to_hpd(1'b1, n);
    chk("R8 wake to hpd edges", n, 7);
    chk("R8 master recaptured", bus_master, 1);
    chk("R8 cfg recaptured", cfg_q, 5);

    // R9 power-down while streaming
    @(negedge clk);
    video_on = 1; pd_req_n = 0;
    wait_cyc(25);
    chk("R9 sleep with video", sleep_o, 1);
    chk("R9 warn set", pd_warn, 1);
    @(negedge clk);
    pd_req_n = 1;
    wait_cyc(4);
    chk("R9 warn cleared on wake", pd_warn, 0);
    wait_cyc(6);
    chk("R7 hpd back", hpd_o, 1);
    video_on = 0;

    // R6 floating power-down input
    @(negedge clk);
    pd_float = 1; pd_req_n = 0;
    wait_cyc(40);
    chk("R6 no sleep when floating", sleep_o, 0);
    chk("R6 hpd stays", hpd_o, 1);
    @(negedge clk);
    pd_float = 0;
    wait_cyc(25);
    chk("R6 sleeps once driven", sleep_o, 1);
    @(negedge clk);
    pd_req_n = 1;
    wait_cyc(10);

    // R10 request pending at end of INIT, with video, across reset
    @(negedge clk);
    strap_mode = 2'b01; video_on = 1; pd_req_n = 0; ext_rst_n = 0;
    repeat (2) @(negedge clk);
    ext_rst_n = 1;
    n = 0; seen = 0;
    do begin
      @(posedge clk); n++; #2;
      if (hpd_o) seen = 1;
    end while (!sleep_o && n < 100);
    chk("R10 sleep edges", n, 23);
    chk("R10 hpd never rose", seen, 0);
    chk("R10 address captured", slave_addr, 8'hC0);
    chk("R10 warn", pd_warn, 1);
    @(negedge clk);
    pd_req_n = 1; video_on = 0;
    wait_cyc(10);
    chk("R8 hpd after final wake", hpd_o, 1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule